// File: doc/BRIEF.md
# Bit-Serial Modular Multiplier With Inline Reduction

This block forms the product of two residues modulo an N-bit odd or even modulus q. It uses shift-and-add. Operand B is read one bit per round, starting from its most significant bit. That bit decides whether the round adds A into the running sum or only doubles the sum. Each round works one bit per clock cycle, least significant bit first.

While a bit of the new partial sum is produced, the same bit is compared against the matching bit of q and of 2q. These two serial comparisons end the round with two flags. The flags pick a correction multiple k in {0,1,2}. The next round subtracts k·q from the sum before doubling it, which it does by removing 2k·q from the doubled sum. No separate reduction multiply takes place. After the last round of B, one more round removes k·q without doubling, which leaves the result below q.

A caller drives both operands and q in parallel and pulses `start` while the block is idle. It then waits for the one-cycle `done` pulse and reads `product`.

Top module: `modmul_serial`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done` and `product` are all zero.
- R2: A `start` sampled while idle captures `op_a`, `op_b` and `modulus` and raises `busy` on the following cycle. Later changes on those inputs do not affect the running product.
- R3: `done` is high for exactly one cycle, (N+1)·(N+1) clock cycles after the edge that accepted `start`. `busy` is low in that cycle.
- R4: For 1 ≤ q < 2^N and A, B < q, `product` equals (A·B) mod q, so it is always below q.
- R5: A `start` pulse that arrives while `busy` is high is ignored. The captured operands stay unchanged and the pending result is that of the first request.
- R6: `product` changes only in the cycle in which `done` is high, and it holds its value until the next completion.
- R7: The corner operands give the values the modular definition requires: A = 0 or B = 0 give 0, B = q−1 gives (q−A) mod q, and q = 1 gives 0.
- R8: The unreduced partial sum carried between rounds stays below 3q throughout a multiplication, so N+2 bits are enough to hold it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse. It is accepted only while `busy` is low |
| op_a | input | N | Multiplicand A, below q |
| op_b | input | N | Multiplier B, below q. Its bits are used from the MSB down |
| modulus | input | N | Modulus q, at least 1 |
| busy | output | 1 | High while a multiplication is in progress |
| done | output | 1 | One-cycle pulse when `product` is updated |
| product | output | N | (A·B) mod q of the last completed request |

## Verification
The bench targets the operand extremes: zero on either side, B = q−1 against large A, and the trivial modulus q = 1. A design that applies the q or 2q correction in the wrong round, or that mis-scales it, shows up there as a result at or above q, or as an off-by-q value. Many random operand pairs under several moduli exercise the carry and borrow path through the top sum bit, which is only formed in the last bit cycle. An error there gives wrong results once the partial sum reaches beyond 2^N. The bench also changes the inputs and re-pulses `start` in mid-run. A block that re-latched its operands would finish with the second request's value or with a shifted latency.

// File: rtl/modmul_serial.sv
module modmul_serial #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] op_a,
  input  logic [N-1:0] op_b,
  input  logic [N-1:0] modulus,
  output logic         busy,
  output logic         done,
  output logic [N-1:0] product
);

  localparam int W  = N + 2;
  localparam int CW = (N + 1 > 1) ? $clog2(N + 1) : 1;
  localparam logic [CW-1:0] LAST = CW'(N);

  logic [N-1:0]  a_q, b_sh, q_q;
  logic [W-1:0]  acc;
  logic [N:0]    nxt;
  logic [1:0]    carry, k_q;
  logic          ge1, ge2;
  logic [CW-1:0] bit_idx, rnd;

  logic          last_rnd, tag;
  logic [W-1:0]  sh_w, add_w, sub_w, nsub, qw, q2w;
  logic [1:0]    cin, cout;
  logic [2:0]    sum_lo;
  logic          s_bit, top_bit;
  logic          ge1_in, ge2_in, ge1_nx, ge2_nx, ge1_fin, ge2_fin;
  logic [N:0]    low_bits;
  logic [W-1:0]  round_val;
  logic [1:0]    k_nx;

  assign last_rnd = (rnd == LAST);
  assign tag      = b_sh[N-1];
  assign qw       = {2'b00, q_q};
  assign q2w      = {1'b0, q_q, 1'b0};

  assign sh_w  = last_rnd ? acc : {acc[W-2:0], 1'b0};
  assign add_w = (!last_rnd && tag) ? {2'b00, a_q} : '0;

  always_comb begin
    if (last_rnd)
      sub_w = (k_q == 2'd2) ? q2w : (k_q == 2'd1) ? qw : '0;
    else
      sub_w = (k_q == 2'd2) ? {q_q, 2'b00} : (k_q == 2'd1) ? q2w : '0;
  end

  assign nsub   = ~sub_w;
  assign cin    = (bit_idx == '0) ? 2'd1 : carry;
  assign sum_lo = {2'b00, sh_w[bit_idx]} + {2'b00, add_w[bit_idx]}
                + {2'b00, nsub[bit_idx]} + {1'b0, cin};
  assign s_bit  = sum_lo[0];
  assign cout   = sum_lo[2:1];
  assign top_bit = sh_w[W-1] ^ add_w[W-1] ^ nsub[W-1] ^ cout[0];

  assign ge1_in  = (bit_idx == '0) ? 1'b1 : ge1;
  assign ge2_in  = (bit_idx == '0) ? 1'b1 : ge2;
  assign ge1_nx  = (s_bit != qw[bit_idx])  ? s_bit : ge1_in;
  assign ge2_nx  = (s_bit != q2w[bit_idx]) ? s_bit : ge2_in;
  assign ge1_fin = (top_bit != qw[W-1])  ? top_bit : ge1_nx;
  assign ge2_fin = (top_bit != q2w[W-1]) ? top_bit : ge2_nx;
  assign k_nx    = ge2_fin ? 2'd2 : (ge1_fin ? 2'd1 : 2'd0);

  always_comb begin
    low_bits = nxt;
    low_bits[bit_idx] = s_bit;
    round_val = {top_bit, low_bits};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= '0; b_sh <= '0; q_q <= '0;
      acc <= '0; nxt <= '0; carry <= '0; k_q <= '0;
      ge1 <= 1'b0; ge2 <= 1'b0;
      bit_idx <= '0; rnd <= '0;
      busy <= 1'b0; done <= 1'b0; product <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          a_q <= op_a; b_sh <= op_b; q_q <= modulus;
          acc <= '0; k_q <= '0; carry <= '0;
          rnd <= '0; bit_idx <= '0;
          busy <= 1'b1;
        end
      end else begin
        nxt[bit_idx] <= s_bit;
        carry <= cout;
        ge1 <= ge1_nx;
        ge2 <= ge2_nx;
        if (bit_idx == LAST) begin
          bit_idx <= '0;
          if (last_rnd) begin
            product <= round_val[N-1:0];
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            acc  <= round_val;
            k_q  <= k_nx;
            rnd  <= rnd + CW'(1);
            b_sh <= {b_sh[N-2:0], 1'b0};
          end
        end else begin
          bit_idx <= bit_idx + CW'(1);
        end
      end
    end
  end

  logic [W:0] three_q;
  assign three_q = {1'b0, q2w} + {1'b0, qw};

  assert_partial_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ({1'b0, acc} < three_q));
  assert_result_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (product < q_q));
  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_operands_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(a_q) && $stable(q_q)));
  assert_product_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(product) |-> done);

endmodule

// File: tb/modmul_serial_test.sv
module modmul_serial_test;
  localparam int N = 8;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = (N + 1) * (N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N-1:0] op_a = '0, op_b = '0, modulus = '0;
  logic busy, done;
  logic [N-1:0] product;

  modmul_serial #(.N(N)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .modulus(modulus), .busy(busy), .done(done), .product(product)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  int exp_q[$];
  int t_q[$];
  string tag_q[$];
  int last_exp = 0;
  logic prev_done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  // monitor: pops the scoreboard when a result completes
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) chk(!done, "R3 single-cycle done", done, 0);
      if (done) begin
        chk(!busy, "R3 busy low at done", busy, 0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5 unexpected completion", 1, 0);
        end else begin
          int e; int t; string g;
          e = exp_q.pop_front();
          t = t_q.pop_front();
          g = tag_q.pop_front();
          chk(int'(product) == e, g, product, e);
          chk(cyc - t == LAT + 1, "R3 latency", cyc - t, LAT + 1);
        end
      end
      prev_done <= done;
    end
  end

  task automatic run_op(input int a, input int b, input int q, input string g, input bit poke);
    while (busy) @(negedge clk);
    op_a = N'(a); op_b = N'(b); modulus = N'(q);
    start = 1'b1;
    exp_q.push_back((a * b) % q);
    t_q.push_back(cyc);
    tag_q.push_back(g);
    last_exp = (a * b) % q;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    op_a = ~op_a; op_b = ~op_b; modulus = modulus ^ 8'h5A;
    if (poke) begin
      @(negedge clk);
      @(negedge clk);
      start = 1'b1;
      op_a = 8'd7; op_b = 8'd9; modulus = 8'd11;
      @(negedge clk);
      @(negedge clk);
      start = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(int'(product) == last_exp, "R6 product holds", product, last_exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1 reset flags", {busy, done}, 0);
    chk(product == '0, "R1 reset product", product, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && product == '0, "R1 after release", product, 0);

    run_op(0, 200, 251, "R7 A zero", 1'b0);
    run_op(137, 0, 251, "R7 B zero", 1'b0);
    run_op(250, 250, 251, "R7 B q-1 max A", 1'b0);
    run_op(3, 250, 251, "R7 B q-1", 1'b0);
    run_op(0, 0, 1, "R7 q one", 1'b0);
    run_op(125, 2, 251, "R4 small", 1'b1);
    run_op(254, 254, 255, "R4 q 255", 1'b1);
    run_op(12, 12, 13, "R4 q 13", 1'b0);
    run_op(1, 1, 2, "R4 q 2", 1'b0);
    for (int i = 0; i < 40; i++) begin
      int q; int a; int b;
      case (i % 4)
        0: q = 251;
        1: q = 255;
        2: q = 97;
        default: q = 128;
      endcase
      a = int'($urandom % q);
      b = int'($urandom % q);
      run_op(a, b, q, "R4 random", (i % 5) == 0);
    end
    finish_run();
  end
endmodule